// File: doc/BRIEF.md
# Packet-to-register-bus command engine

This block sits behind a link layer that has already removed framing and verified the checksum. It receives one command packet at a time as a byte stream and turns it into a run of single-byte reads or writes on an internal register bus. The first four bytes of a packet are a header: the command byte, the peripheral selector, the starting register number and the request count. Write packets then carry their payload. The bus address joins a 4-bit peripheral number and an 8-bit register number.

A command asks for one of two address modes. In the first, every access targets the same register, which suits a peripheral FIFO. In the second, the register number advances after each access. A peripheral takes or supplies each byte by raising an accept strobe in the same cycle as the access. When it refuses a byte, the run ends at once, so the number of completed bytes can be lower than the request.

After the run, the block emits a one-cycle response descriptor for a downstream response builder. The descriptor carries the echoed header, the completed count and an error flag. Read bytes go out on a separate byte strobe as they arrive. Write payload is staged in a local buffer until the whole packet has been checked, so a malformed packet never reaches the bus.

Top module: `pcmd_engine`

## Requirements
- R1: Command 0x04 (read, fixed register) and 0x06 (read, advancing register) issue `bus_rd` accesses. Each accepted read byte appears on `rd_data` with `rd_valid` high, one cycle after the accepting edge, in bus order.
- R2: Command 0x08 (write, fixed register) and 0x0A (write, advancing register) issue `bus_wr` accesses. Payload byte k is driven on `bus_wdata` during access k.
- R3: Command bit 1 selects the address mode. When it is set, access k targets register start+k. When it is clear, every access targets the start register.
- R4: The advancing register number wraps from 0xFF to 0x00 and never changes the peripheral field `bus_addr[11:8]`.
- R5: `bus_addr` is {selector byte bits 3:0, register number}. Header byte order is command, selector, register, count.
- R6: An access with `bus_ack` low ends the run. No further access follows it. The completed count equals the number of accesses accepted before it, and the refused access is not counted.
- R7: A command byte other than 0x04, 0x06, 0x08 or 0x0A gives a response with `rsp_err`=1 and `rsp_xfer`=0, and issues no bus access.
- R8: A selector byte whose bits 7:4 are not 4'b1110 gives an error response and issues no bus access.
- R9: An error response with no bus access also results from any of these: a packet shorter than four bytes, a write whose payload length differs from the request count, or a read that carries any payload.
- R10: A request count of 0 gives a response with `rsp_err`=0 and `rsp_xfer`=0, and issues no bus access.
- R11: `rsp_valid` is a one-cycle pulse per packet. For a well-formed packet it echoes the command, peripheral number, start register and request count. `rsp_xfer` equals the request count when every access is accepted.
- R12: `in_ready` is high after reset. It is low from the cycle after a packet's last byte until the cycle after `rsp_valid`, and is high in that following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet byte present |
| in_byte | input | 8 | Packet byte |
| in_last | input | 1 | Marks the final byte of a packet |
| in_ready | output | 1 | Block accepts a packet byte this cycle |
| bus_addr | output | 12 | Peripheral number and register number |
| bus_rd | output | 1 | Read access strobe |
| bus_wr | output | 1 | Write access strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data from the selected peripheral |
| bus_ack | input | 1 | Peripheral accepts or supplies the byte this cycle |
| rd_valid | output | 1 | Read byte strobe toward the response builder |
| rd_data | output | 8 | Read byte |
| rsp_valid | output | 1 | Response descriptor strobe |
| rsp_err | output | 1 | Packet rejected |
| rsp_cmd | output | 8 | Echoed command byte |
| rsp_periph | output | 4 | Echoed peripheral number |
| rsp_reg | output | 8 | Echoed start register |
| rsp_req | output | 8 | Echoed request count |
| rsp_xfer | output | 8 | Bytes completed |

## Verification
The bench targets several corner cases:
- A peripheral that refuses the very first access, and one that refuses partway through a read or write. A sequencer that counted the refused byte, or kept strobing afterwards, would report too many bytes or show extra bus activity.
- Advancing runs that cross register 0xFF, including a full 255-byte read. A carry into the peripheral field would move the access to the wrong peripheral.
- Payloads one byte short and one byte long, a read that carries payload, a truncated header, a combined read-and-write command and a wrong selector prefix. Each of these must be rejected with no bus access; a design that checked too late would already have written the peripheral.
- A zero-length request. A sequencer that started before testing the count would issue one unwanted access.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 8;
    localparam int PID_W   = 4;
    localparam int ADDR_W  = PID_W + REG_W;
    localparam int HDR_LEN = 4;
    localparam logic [3:0] PID_TAG = 4'hE;
    localparam int RD_BIT  = 2;
    localparam int WR_BIT  = 3;
    localparam int INC_BIT = 1;

    typedef enum logic {PS_COLLECT, PS_WAIT} ps_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_RUN, SQ_DONE} sq_e;

    function automatic logic cmd_known(input logic [BYTE_W-1:0] c);
        return (c == 8'h04) || (c == 8'h06) || (c == 8'h08) || (c == 8'h0A);
    endfunction
endpackage

// File: rtl/pcmd_wbuf.sv
module pcmd_wbuf #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pcmd_parse.sv
module pcmd_parse
    import pcmd_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    localparam int BUF_AW   = $clog2(BUF_DEPTH),
    localparam int CNT_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              seq_done,
    output logic              start,
    output logic              hdr_err,
    output logic [BYTE_W-1:0] h_cmd,
    output logic [PID_W-1:0]  h_pid,
    output logic [REG_W-1:0]  h_reg,
    output logic [BYTE_W-1:0] h_req,
    output logic              wb_we,
    output logic [BUF_AW-1:0] wb_waddr,
    output logic [BYTE_W-1:0] wb_wdata
);
    typedef struct packed {
        ps_e               st;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] pid;
        logic [REG_W-1:0]  rnum;
        logic [BYTE_W-1:0] req;
        logic [CNT_W-1:0]  cnt;
        logic              start;
        logic              err;
    } pp_t;

    pp_t p_d, p_q;
    logic take;
    logic [CNT_W:0] total, want;
    logic [CNT_W-1:0] doff;

    always_comb begin
        p_d     = p_q;
        p_d.start = 1'b0;
        take    = in_valid && (p_q.st == PS_COLLECT);
        total   = {1'b0, p_q.cnt} + 1'b1;
        doff    = p_q.cnt - CNT_W'(HDR_LEN);
        want    = '0;
        if (take) begin
            if (p_q.cnt == CNT_W'(0)) p_d.cmd  = in_byte;
            if (p_q.cnt == CNT_W'(1)) p_d.pid  = in_byte;
            if (p_q.cnt == CNT_W'(2)) p_d.rnum = in_byte;
            if (p_q.cnt == CNT_W'(3)) p_d.req  = in_byte;
            if (p_q.cnt != '1) p_d.cnt = p_q.cnt + 1'b1;
            if (in_last) begin
                want = (CNT_W+1)'(HDR_LEN) +
                       (p_d.cmd[WR_BIT] ? (CNT_W+1)'(p_d.req) : '0);
                p_d.err = (total < (CNT_W+1)'(HDR_LEN)) || !cmd_known(p_d.cmd) ||
                          (p_d.pid[BYTE_W-1:BYTE_W-4] != PID_TAG) || (total != want);
                p_d.start = 1'b1;
                p_d.st    = PS_WAIT;
                p_d.cnt   = '0;
            end
        end
        if ((p_q.st == PS_WAIT) && seq_done) p_d.st = PS_COLLECT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign in_ready = (p_q.st == PS_COLLECT);
    assign start    = p_q.start;
    assign hdr_err  = p_q.err;
    assign h_cmd    = p_q.cmd;
    assign h_pid    = p_q.pid[PID_W-1:0];
    assign h_reg    = p_q.rnum;
    assign h_req    = p_q.req;
    assign wb_we    = take && (p_q.cnt >= CNT_W'(HDR_LEN)) && (doff < CNT_W'(BUF_DEPTH));
    assign wb_waddr = BUF_AW'(doff);
    assign wb_wdata = in_byte;

    // R12
    start_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !in_ready);
endmodule

// File: rtl/pcmd_seq.sv
module pcmd_seq
    import pcmd_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hdr_err,
    input  logic [BYTE_W-1:0] h_cmd,
    input  logic [PID_W-1:0]  h_pid,
    input  logic [REG_W-1:0]  h_reg,
    input  logic [BYTE_W-1:0] h_req,
    output logic [BUF_AW-1:0] wb_raddr,
    input  logic [BYTE_W-1:0] wb_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              seq_done,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [BYTE_W-1:0] rsp_cmd,
    output logic [PID_W-1:0]  rsp_periph,
    output logic [REG_W-1:0]  rsp_reg,
    output logic [BYTE_W-1:0] rsp_req,
    output logic [BYTE_W-1:0] rsp_xfer
);
    typedef struct packed {
        sq_e               st;
        logic [BYTE_W-1:0] cmd;
        logic [PID_W-1:0]  pid;
        logic [REG_W-1:0]  rstart;
        logic [REG_W-1:0]  cur;
        logic [BYTE_W-1:0] req;
        logic [BYTE_W-1:0] xfer;
        logic              err;
        logic              rdv;
        logic [BYTE_W-1:0] rdd;
    } sq_t;

    sq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rdv = 1'b0;
        unique case (s_q.st)
            SQ_IDLE: if (start) begin
                s_d.cmd    = h_cmd;
                s_d.pid    = h_pid;
                s_d.rstart = h_reg;
                s_d.cur    = h_reg;
                s_d.req    = h_req;
                s_d.xfer   = '0;
                s_d.err    = hdr_err;
                s_d.st     = (hdr_err || (h_req == '0)) ? SQ_DONE : SQ_RUN;
            end
            SQ_RUN: begin
                if (bus_ack) begin
                    s_d.xfer = s_q.xfer + 1'b1;
                    if (s_q.cmd[INC_BIT]) s_d.cur = s_q.cur + 1'b1;
                    if (s_q.cmd[RD_BIT]) begin
                        s_d.rdv = 1'b1;
                        s_d.rdd = bus_rdata;
                    end
                    if (s_d.xfer == s_q.req) s_d.st = SQ_DONE;
                end else begin
                    s_d.st = SQ_DONE;
                end
            end
            SQ_DONE: s_d.st = SQ_IDLE;
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rd     = (s_q.st == SQ_RUN) && s_q.cmd[RD_BIT];
    assign bus_wr     = (s_q.st == SQ_RUN) && s_q.cmd[WR_BIT];
    assign bus_addr   = {s_q.pid, s_q.cur};
    assign wb_raddr   = BUF_AW'(s_q.xfer);
    assign bus_wdata  = wb_rdata;
    assign rd_valid   = s_q.rdv;
    assign rd_data    = s_q.rdd;
    assign seq_done   = (s_q.st == SQ_DONE);
    assign rsp_valid  = seq_done;
    assign rsp_err    = s_q.err;
    assign rsp_cmd    = s_q.cmd;
    assign rsp_periph = s_q.pid;
    assign rsp_reg    = s_q.rstart;
    assign rsp_req    = s_q.req;
    assign rsp_xfer   = s_q.xfer;

    // R6
    stop_on_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && !bus_ack |=> !(bus_rd || bus_wr));
    // R4
    periph_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && $past(bus_rd || bus_wr) |->
        bus_addr[ADDR_W-1:REG_W] == $past(bus_addr[ADDR_W-1:REG_W]));
    // R3
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && $past(bus_rd || bus_wr) && !rsp_cmd[INC_BIT] |->
        $stable(bus_addr));
    // R7
    err_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_xfer == '0);
    // R11
    xfer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_xfer <= rsp_req);
endmodule

// File: rtl/pcmd_engine.sv
module pcmd_engine
    import pcmd_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    localparam int BUF_AW   = $clog2(BUF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_last,
    output logic              in_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [BYTE_W-1:0] rsp_cmd,
    output logic [PID_W-1:0]  rsp_periph,
    output logic [REG_W-1:0]  rsp_reg,
    output logic [BYTE_W-1:0] rsp_req,
    output logic [BYTE_W-1:0] rsp_xfer
);
    logic              start, hdr_err, seq_done, wb_we;
    logic [BYTE_W-1:0] h_cmd, h_req, wb_wdata, wb_rdata;
    logic [PID_W-1:0]  h_pid;
    logic [REG_W-1:0]  h_reg;
    logic [BUF_AW-1:0] wb_waddr, wb_raddr;

    pcmd_parse #(.BUF_DEPTH(BUF_DEPTH)) u_parse (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_ready(in_ready), .seq_done(seq_done),
        .start(start), .hdr_err(hdr_err), .h_cmd(h_cmd), .h_pid(h_pid),
        .h_reg(h_reg), .h_req(h_req), .wb_we(wb_we), .wb_waddr(wb_waddr),
        .wb_wdata(wb_wdata)
    );

    pcmd_wbuf #(.DEPTH(BUF_DEPTH), .W(BYTE_W)) u_wbuf (
        .clk(clk), .we(wb_we), .waddr(wb_waddr), .wdata(wb_wdata),
        .raddr(wb_raddr), .rdata(wb_rdata)
    );

    pcmd_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .hdr_err(hdr_err),
        .h_cmd(h_cmd), .h_pid(h_pid), .h_reg(h_reg), .h_req(h_req),
        .wb_raddr(wb_raddr), .wb_rdata(wb_rdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .seq_done(seq_done), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_cmd(rsp_cmd), .rsp_periph(rsp_periph),
        .rsp_reg(rsp_reg), .rsp_req(rsp_req), .rsp_xfer(rsp_xfer)
    );

    // R12
    bus_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> !in_ready);
    // R1
    single_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

// File: tb/pcmd_engine_tb.sv
module pcmd_engine_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, in_valid, in_last, in_ready;
    logic [7:0]  in_byte;
    logic [11:0] bus_addr;
    logic        bus_rd, bus_wr, bus_ack, rd_valid, rsp_valid, rsp_err;
    logic [7:0]  bus_wdata, bus_rdata, rd_data, rsp_cmd, rsp_reg, rsp_req, rsp_xfer;
    logic [3:0]  rsp_periph;

    pcmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_last(in_last), .in_ready(in_ready), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_cmd(rsp_cmd), .rsp_periph(rsp_periph), .rsp_reg(rsp_reg),
        .rsp_req(rsp_req), .rsp_xfer(rsp_xfer)
    );

    // bench peripheral model: accepts the first ack_lim accesses of a packet
    logic       clr;
    logic [8:0] ack_lim;
    int acc_n, try_n, rd_n;
    logic [11:0] log_addr [256];
    logic [7:0]  log_data [256];
    logic [7:0]  rd_log   [256];

    assign bus_ack   = (acc_n < int'(ack_lim));
    assign bus_rdata = bus_addr[7:0] ^ {bus_addr[11:8], 4'hA};

    always @(posedge clk) begin
        if (clr) begin
            acc_n <= 0; try_n <= 0; rd_n <= 0;
        end else begin
            if (bus_rd || bus_wr) begin
                try_n <= try_n + 1;
                if (bus_ack && acc_n < 256) begin
                    log_addr[acc_n] <= bus_addr;
                    log_data[acc_n] <= bus_wdata;
                    acc_n <= acc_n + 1;
                end
            end
            if (rd_valid && rd_n < 256) begin
                rd_log[rd_n] <= rd_data;
                rd_n <= rd_n + 1;
            end
        end
    end

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // {cmd, pid, reg, req, ndata, ack_lim(FF=all), exp_xfer, exp_err}
    localparam int NV = 16;
    localparam logic [63:0] VEC [NV] = '{
        64'h06_E3_10_05_00_FF_05_00,  // R1 R3 advancing read
        64'h04_E5_20_04_00_FF_04_00,  // R1 R3 fixed read
        64'h0A_E2_FD_06_06_FF_06_00,  // R2 R4 advancing write across 0xFF
        64'h08_E7_40_03_03_FF_03_00,  // R2 R3 fixed write
        64'h08_E1_41_06_06_02_02_00,  // R6 write refused at byte 2
        64'h06_E0_00_04_00_00_00_00,  // R6 first access refused
        64'h0C_E1_00_02_00_FF_00_01,  // R7 combined bits
        64'h02_E1_00_02_00_FF_00_01,  // R7 unknown
        64'h06_D1_00_02_00_FF_00_01,  // R8 bad prefix
        64'h0A_E1_00_03_02_FF_00_01,  // R9 payload short
        64'h0A_E1_00_02_03_FF_00_01,  // R9 payload long
        64'h06_E4_00_00_00_FF_00_00,  // R10 zero count
        64'h06_EF_80_FF_00_FF_FF_00,  // R4 R11 255-byte read with wrap
        64'h04_E9_33_03_01_FF_00_01,  // R9 read with payload
        64'h0A_E6_F0_05_05_03_03_00,  // R6 advancing write stopped
        64'h06_EA_10_06_00_04_04_00   // R6 read stopped
    };

    task automatic send_pkt(input logic [7:0] c, p, r, q, input int nd, input int nhdr);
        for (int i = 0; i < nhdr + nd; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_last  = (i == nhdr + nd - 1);
            in_byte  = (i == 0) ? c : (i == 1) ? p : (i == 2) ? r : (i == 3) ? q :
                       8'(8'h30 + i - 4);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(in_ready == 1'b0, "R12", "ready after last byte", in_ready, 0);
    endtask

    task automatic wait_rsp(output bit got);
        int t = 0;
        got = 1'b0;
        while (!rsp_valid && t < 2000) begin @(negedge clk); t++; end
        got = rsp_valid;
    endtask

    task automatic run_pkt(input logic [7:0] c, p, r, q, input int nd, input int nhdr,
                           input logic [7:0] lim, input int exp_xfer, input bit exp_err);
        bit got, e;
        int x, bad, exp_rd;
        logic [7:0] rc, rr, rq; logic [3:0] rp;
        @(negedge clk); clr = 1'b1;
        ack_lim = (lim == 8'hFF) ? 9'd256 : {1'b0, lim};
        @(negedge clk); clr = 1'b0;
        send_pkt(c, p, r, q, nd, nhdr);
        wait_rsp(got);
        chk(got, "R11", "response seen", got, 1);
        e = rsp_err; x = rsp_xfer; rc = rsp_cmd; rp = rsp_periph; rr = rsp_reg; rq = rsp_req;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12", "ready after response", in_ready, 1);
        chk(rsp_valid == 1'b0, "R11", "response is one pulse", rsp_valid, 0);
        chk(e == exp_err, "R7/R8/R9", "error flag", e, exp_err);
        chk(x == exp_xfer, "R6/R10/R11", "transfer count", x, exp_xfer);
        if (!exp_err)
            chk(rc == c && rp == p[3:0] && rr == r && rq == q, "R11", "header echo",
                {rc, rr}, {c, r});
        chk(acc_n == exp_xfer, "R6", "accepted accesses", acc_n, exp_xfer);
        chk(try_n == exp_xfer + ((!exp_err && exp_xfer < q) ? 1 : 0), "R6/R7/R10",
            "bus accesses", try_n, exp_xfer + ((!exp_err && exp_xfer < q) ? 1 : 0));
        bad = 0;
        for (int k = 0; k < acc_n && k < 256; k++) begin
            logic [11:0] ea;
            ea = {p[3:0], c[1] ? 8'(r + k) : r};
            if (log_addr[k] != ea) bad++;
            if (c[3] && log_data[k] != 8'(8'h30 + k)) bad++;
        end
        chk(bad == 0, "R2/R3/R4/R5", "address and data sequence", bad, 0);
        exp_rd = (c[2] && !exp_err) ? exp_xfer : 0;
        chk(rd_n == exp_rd, "R1", "read byte count", rd_n, exp_rd);
        bad = 0;
        for (int k = 0; k < rd_n && k < 256; k++) begin
            logic [11:0] ea;
            ea = {p[3:0], c[1] ? 8'(r + k) : r};
            if (rd_log[k] != (ea[7:0] ^ {ea[11:8], 4'hA})) bad++;
        end
        chk(bad == 0, "R1", "read byte values", bad, 0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_byte = '0;
        clr = 1'b1; ack_lim = 9'd256;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!bus_rd && !bus_wr && !rsp_valid && !rd_valid, "R12", "idle in reset",
            {bus_rd, bus_wr, rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R12", "ready after reset", in_ready, 1);

        for (int v = 0; v < NV; v++) begin
            logic [63:0] w;
            w = VEC[v];
            run_pkt(w[63:56], w[55:48], w[47:40], w[39:32], int'(w[31:24]), 4,
                    w[23:16], int'(w[15:8]), w[0]);
        end

        // R9 truncated headers, then back-to-back recovery
        run_pkt(8'h06, 8'hE1, 8'h00, 8'h00, 0, 2, 8'hFF, 0, 1'b1);
        run_pkt(8'h06, 8'hE1, 8'h00, 8'h00, 0, 1, 8'hFF, 0, 1'b1);
        // R5 R3 fixed read on peripheral 0 after an error
        run_pkt(8'h04, 8'hE0, 8'hFF, 8'h02, 0, 4, 8'hFF, 2, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule